// File: doc/BRIEF.md
# Segmented CAM Array with Entry Validity

This block is a small content-addressable memory of `ENTRIES` locations, each `4*SEG_W` bits wide (64 bits with the default 16-bit segments). A global split code marks some segments of every entry as compared key segments. The remaining segments hold associated data that is stored and read back but never compared. Each entry also carries a two-bit validity type. A compare only considers entries of one type. For an automatic compare that type is fixed to "valid". For an explicit compare it is chosen by the command.

All operations come through a one-cycle synchronous command port. The commands are: load the comparand, which also runs a compare; load the mask register; run an explicit compare; write an entry; read an entry; set validity only; and load the address register. Writes, reads and validity updates pick their target in one of four ways: an absolute address, the auto-incrementing address register, the latched best-match address, or the lowest empty entry. The block reports a match flag, a multiple-match flag, the best-match address, a full flag and the next-free address. A read also returns the entry's data and its validity type.

Top module: `seg_cam`

## Requirements
- R1: After reset every entry holds all-zero data with validity type empty. The mask register and the address register are zero. `match`, `multi` and `match_addr` are 0, `full` is 0 and `free_addr` is 0.
- R2: `split_cfg` selects the compared segments, where segment 0 is bits [SEG_W-1:0]. Codes 0..3 compare segments 0..k (k = code). Codes 4, 5 and 6 compare segments 3, 2..3 and 1..3. Code 7 compares all four segments.
- R3: Bits in non-compared segments never affect a compare. When `cmd_mask_en` is 1, every bit set in the mask register is also excluded from the compare.
- R4: The validity code {skip,empty} is 2'b00 valid, 2'b01 empty, 2'b10 skip and 2'b11 RAM. Load-comparand (op 1) stores `cmd_data` as the comparand and compares it only against entries of type valid.
- R5: Compare (op 3) compares the stored comparand only against entries whose type equals `cmd_vtype`.
- R6: One clock after a compare, `match` shows whether any entry hit and `multi` shows whether more than one hit. `match_addr` is the lowest-numbered hit, or 0 when there is none.
- R7: `free_addr` is the lowest-numbered empty entry and `full` is 1 when no entry is empty, in which case `free_addr` is 0. Both follow the array from the clock after any write or validity change.
- R8: Write (op 4) stores `cmd_data` and `cmd_vtype` at the target. `cmd_mode` selects the target: 0 is `cmd_addr`, 1 is the address register, 2 is `match_addr`, 3 is `free_addr`. Mode 2 without a match and mode 3 when full do nothing.
- R9: Read (op 5) puts the target's data on `rd_data` and its validity on `rd_status` one clock later. Load-address (op 7) sets the address register to `cmd_addr`. Any op 4/5/6 that uses mode 1 advances the address register by one, wrapping to 0 after the last entry.
- R10: Load-mask (op 2) stores `cmd_data` in the mask register and leaves `match`, `multi` and `match_addr` unchanged.
- R11: Set-validity (op 6) writes `cmd_vtype` into the target's validity and leaves its data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| split_cfg | input | 3 | Global compare/store split code |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 3 | Command code |
| cmd_mode | input | 2 | Target selection for write/read/set-validity |
| cmd_addr | input | AW | Absolute address or address-register load value |
| cmd_data | input | 4*SEG_W | Write data, comparand or mask |
| cmd_vtype | input | 2 | Validity written, or type compared |
| cmd_mask_en | input | 1 | Apply the mask register to this compare |
| match | output | 1 | Last compare found a hit |
| multi | output | 1 | Last compare found more than one hit |
| match_addr | output | AW | Lowest hit of the last compare |
| full | output | 1 | No empty entry remains |
| free_addr | output | AW | Lowest empty entry |
| rd_data | output | 4*SEG_W | Data of the last read |
| rd_status | output | 2 | Validity of the last read |

## Verification
Compare results (`match`, `multi`, `match_addr`) and read results (`rd_data`, `rd_status`) are registered, so they are due one clock after the edge that takes the command. `full` and `free_addr` follow the validity array, so they change at that same edge. The bench drives each command on a falling edge and samples all results at the next falling edge. That sample comes after exactly one rising edge, which covers both latencies. After reset is released, the bench waits three rising edges so that the two-stage release has completed before the reset state is sampled.

// File: rtl/cam_seg_pkg.sv
package cam_seg_pkg;

  localparam int NSEG = 4;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_LDCMP  = 3'd1,
    OP_LDMASK = 3'd2,
    OP_CMP    = 3'd3,
    OP_WRITE  = 3'd4,
    OP_READ   = 3'd5,
    OP_SETVAL = 3'd6,
    OP_LDADDR = 3'd7
  } cam_op_e;

  typedef enum logic [1:0] {
    TG_ABS   = 2'd0,
    TG_AREG  = 2'd1,
    TG_MATCH = 2'd2,
    TG_FREE  = 2'd3
  } cam_tgt_e;

  // {skip, empty}
  typedef enum logic [1:0] {
    VT_VALID = 2'b00,
    VT_EMPTY = 2'b01,
    VT_SKIP  = 2'b10,
    VT_RAM   = 2'b11
  } cam_vt_e;

  function automatic logic [NSEG-1:0] seg_sel(input logic [2:0] code);
    case (code)
      3'd0:    seg_sel = 4'b0001;
      3'd1:    seg_sel = 4'b0011;
      3'd2:    seg_sel = 4'b0111;
      3'd4:    seg_sel = 4'b1000;
      3'd5:    seg_sel = 4'b1100;
      3'd6:    seg_sel = 4'b1110;
      default: seg_sel = 4'b1111;
    endcase
  endfunction

endpackage

// File: rtl/cam_prio_enc.sv
module cam_prio_enc #(
  parameter int N = 16,
  localparam int AW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic          multi,
  output logic [AW-1:0] idx
);

  always_comb begin
    any   = 1'b0;
    multi = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = AW'(i);
    end
    for (int i = 0; i < N; i++) begin
      if (req[i]) begin
        if (any) multi = 1'b1;
        any = 1'b1;
      end
    end
  end

  // R6: the reported index always points at a requesting line
  always_comb begin
    if (!$isunknown(req) && any) begin
      p_idx_is_hit_r6: assert (req[idx]);
    end
  end

endmodule

// File: rtl/cam_match_unit.sv
module cam_match_unit #(
  parameter int N = 16,
  parameter int W = 64
) (
  input  logic [N-1:0][W-1:0] ent,
  input  logic [N-1:0][1:0]   vt,
  input  logic [W-1:0]        key,
  input  logic [W-1:0]        care,
  input  logic [1:0]          vsel,
  output logic [N-1:0]        hit
);

  for (genvar i = 0; i < N; i++) begin : g_line
    assign hit[i] = (vt[i] == vsel) && (((ent[i] ^ key) & care) == '0);
  end

endmodule

// File: rtl/seg_cam.sv
module seg_cam
  import cam_seg_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int SEG_W   = 16,
  localparam int AW = $clog2(ENTRIES),
  localparam int W  = NSEG * SEG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    split_cfg,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [1:0]    cmd_mode,
  input  logic [AW-1:0] cmd_addr,
  input  logic [W-1:0]  cmd_data,
  input  logic [1:0]    cmd_vtype,
  input  logic          cmd_mask_en,
  output logic          match,
  output logic          multi,
  output logic [AW-1:0] match_addr,
  output logic          full,
  output logic [AW-1:0] free_addr,
  output logic [W-1:0]  rd_data,
  output logic [1:0]    rd_status
);

  // reset: asserted asynchronously, released after two clocks
  logic [1:0] rst_pipe;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  // state
  logic [ENTRIES-1:0][W-1:0] ent_q;
  logic [ENTRIES-1:0][1:0]   vt_q;
  logic [W-1:0]              cmp_q, mask_q;
  logic [AW-1:0]             areg_q;
  logic                      match_q, multi_q;
  logic [AW-1:0]             maddr_q;
  logic [W-1:0]              rdat_q;
  logic [1:0]                rvt_q;

  // compare path
  logic [NSEG-1:0]    seg_en;
  logic [W-1:0]       care_seg, care_eff, key;
  logic [1:0]         vsel;
  logic [ENTRIES-1:0] hit, empty_vec;
  logic               hit_any, hit_multi, free_any;
  logic [AW-1:0]      hit_idx, free_idx;

  assign seg_en = seg_sel(split_cfg);

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    assign care_seg[s*SEG_W +: SEG_W] = {SEG_W{seg_en[s]}};
  end

  assign care_eff = care_seg & ~(cmd_mask_en ? mask_q : '0);
  assign key      = (cmd_op == OP_LDCMP) ? cmd_data : cmp_q;
  assign vsel     = (cmd_op == OP_LDCMP) ? VT_VALID : cmd_vtype;

  cam_match_unit #(.N(ENTRIES), .W(W)) u_match (
    .ent (ent_q),
    .vt  (vt_q),
    .key (key),
    .care(care_eff),
    .vsel(vsel),
    .hit (hit)
  );

  cam_prio_enc #(.N(ENTRIES)) u_hit_enc (
    .req  (hit),
    .any  (hit_any),
    .multi(hit_multi),
    .idx  (hit_idx)
  );

  for (genvar i = 0; i < ENTRIES; i++) begin : g_empty
    assign empty_vec[i] = (vt_q[i] == VT_EMPTY);
  end

  logic free_multi_unused;
  cam_prio_enc #(.N(ENTRIES)) u_free_enc (
    .req  (empty_vec),
    .any  (free_any),
    .multi(free_multi_unused),
    .idx  (free_idx)
  );

  // next-state: target decode and enables
  logic [AW-1:0] tgt, areg_d;
  logic          tgt_ok, is_acc;
  logic          ent_we, vt_we, rd_we, cmp_we, mask_we, res_we, areg_we;

  always_comb begin
    case (cam_tgt_e'(cmd_mode))
      TG_ABS:   begin tgt = cmd_addr; tgt_ok = (32'(cmd_addr) < ENTRIES); end
      TG_AREG:  begin tgt = areg_q;   tgt_ok = 1'b1;     end
      TG_MATCH: begin tgt = maddr_q;  tgt_ok = match_q;  end
      default:  begin tgt = free_idx; tgt_ok = free_any; end
    endcase

    is_acc  = cmd_valid && (cmd_op == OP_WRITE || cmd_op == OP_READ || cmd_op == OP_SETVAL);
    ent_we  = cmd_valid && (cmd_op == OP_WRITE) && tgt_ok;
    vt_we   = cmd_valid && (cmd_op == OP_WRITE || cmd_op == OP_SETVAL) && tgt_ok;
    rd_we   = cmd_valid && (cmd_op == OP_READ) && tgt_ok;
    cmp_we  = cmd_valid && (cmd_op == OP_LDCMP);
    mask_we = cmd_valid && (cmd_op == OP_LDMASK);
    res_we  = cmd_valid && (cmd_op == OP_LDCMP || cmd_op == OP_CMP);

    areg_we = 1'b0;
    areg_d  = areg_q;
    if (cmd_valid && cmd_op == OP_LDADDR) begin
      areg_we = 1'b1;
      areg_d  = cmd_addr;
    end else if (is_acc && cmd_mode == TG_AREG) begin
      areg_we = 1'b1;
      areg_d  = (32'(areg_q) == ENTRIES - 1) ? '0 : areg_q + 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ent_q   <= '0;
      vt_q    <= {ENTRIES{VT_EMPTY}};
      cmp_q   <= '0;
      mask_q  <= '0;
      areg_q  <= '0;
      match_q <= 1'b0;
      multi_q <= 1'b0;
      maddr_q <= '0;
      rdat_q  <= '0;
      rvt_q   <= VT_EMPTY;
    end else begin
      if (ent_we)  ent_q[tgt] <= cmd_data;
      if (vt_we)   vt_q[tgt]  <= cmd_vtype;
      if (cmp_we)  cmp_q      <= cmd_data;
      if (mask_we) mask_q     <= cmd_data;
      if (areg_we) areg_q     <= areg_d;
      if (res_we) begin
        match_q <= hit_any;
        multi_q <= hit_multi;
        maddr_q <= hit_idx;
      end
      if (rd_we) begin
        rdat_q <= ent_q[tgt];
        rvt_q  <= vt_q[tgt];
      end
    end
  end

  assign match      = match_q;
  assign multi      = multi_q;
  assign match_addr = maddr_q;
  assign full       = !free_any;
  assign free_addr  = free_idx;
  assign rd_data    = rdat_q;
  assign rd_status  = rvt_q;

  // assertions
  p_multi_has_match_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    multi_q |-> match_q);

  p_free_is_empty_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    !full |-> (vt_q[free_addr] == VT_EMPTY));

  p_mask_keeps_match_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    (cmd_valid && cmd_op == OP_LDMASK) |=> ($stable(match_q) && $stable(maddr_q)));

  p_read_status_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    rd_we |=> (rd_status == $past(vt_q[tgt])));

  p_full_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    (cmd_valid && cmd_op == OP_WRITE && cmd_mode == TG_FREE && full) |=> $stable(vt_q));

endmodule

// File: tb/seg_cam_tb_top.sv
module seg_cam_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int W  = 64;

  localparam logic [63:0] DA = 64'h1111_2222_3333_4444;
  localparam logic [63:0] DB = 64'h1111_2222_3333_5555;
  localparam logic [63:0] DC = 64'hABCD_0000_0000_0001;
  localparam logic [63:0] DD = 64'h0F0F_0F0F_0F0F_0F0F;

  localparam logic [2:0] CM = 3'b100, CF = 3'b010, CD = 3'b001;

  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  mode;
    logic [3:0]  addr;
    logic [63:0] data;
    logic [1:0]  vt;
    logic        men;
    logic [2:0]  split;
    logic [2:0]  chk;
    logic        em;
    logic        emm;
    logic [3:0]  ema;
    logic        ef;
    logic [3:0]  efa;
    logic [63:0] erd;
    logic [1:0]  ers;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VECS [NV] = '{
    '{3'd4, 2'd0, 4'd2,  DA, 2'd0, 1'b0, 3'd3, CF, 1'b0, 1'b0, 4'd0, 1'b0, 4'd0, 64'd0, 2'd0, 4'd8},  // R8 abs write
    '{3'd4, 2'd3, 4'd0,  DB, 2'd0, 1'b0, 3'd3, CF, 1'b0, 1'b0, 4'd0, 1'b0, 4'd1, 64'd0, 2'd0, 4'd7},  // R7 free write
    '{3'd4, 2'd3, 4'd0,  DA, 2'd0, 1'b0, 3'd3, CF, 1'b0, 1'b0, 4'd0, 1'b0, 4'd3, 64'd0, 2'd0, 4'd7},  // R7
    '{3'd1, 2'd0, 4'd0,  DA, 2'd0, 1'b0, 3'd3, CM, 1'b1, 1'b1, 4'd1, 1'b0, 4'd0, 64'd0, 2'd0, 4'd6},  // R6 lowest of two
    '{3'd1, 2'd0, 4'd0,  DB, 2'd0, 1'b0, 3'd3, CM, 1'b1, 1'b0, 4'd0, 1'b0, 4'd0, 64'd0, 2'd0, 4'd6},  // R6 single
    '{3'd1, 2'd0, 4'd0,  64'h9999_9999_9999_9999, 2'd0, 1'b0, 3'd3, CM, 1'b0, 1'b0, 4'd0, 1'b0, 4'd0, 64'd0, 2'd0, 4'd4}, // R4 miss
    '{3'd1, 2'd0, 4'd0,  64'h1111_0000_0000_0000, 2'd0, 1'b0, 3'd4, CM, 1'b1, 1'b1, 4'd0, 1'b0, 4'd0, 64'd0, 2'd0, 4'd2}, // R2 top only
    '{3'd1, 2'd0, 4'd0,  64'hFFFF_FFFF_FFFF_5555, 2'd0, 1'b0, 3'd0, CM, 1'b1, 1'b0, 4'd0, 1'b0, 4'd0, 64'd0, 2'd0, 4'd2}, // R2 low only
    '{3'd2, 2'd0, 4'd0,  64'h0000_0000_0000_FFFF, 2'd0, 1'b0, 3'd3, CM, 1'b1, 1'b0, 4'd0, 1'b0, 4'd0, 64'd0, 2'd0, 4'd10}, // R10
    '{3'd1, 2'd0, 4'd0,  64'h1111_2222_3333_0000, 2'd0, 1'b1, 3'd3, CM, 1'b1, 1'b1, 4'd0, 1'b0, 4'd0, 64'd0, 2'd0, 4'd3}, // R3 masked
    '{3'd1, 2'd0, 4'd0,  64'h1111_2222_3333_0000, 2'd0, 1'b0, 3'd3, CM, 1'b0, 1'b0, 4'd0, 1'b0, 4'd0, 64'd0, 2'd0, 4'd3}, // R3 unmasked
    '{3'd6, 2'd0, 4'd0,  64'd0, 2'd2, 1'b0, 3'd3, CF, 1'b0, 1'b0, 4'd0, 1'b0, 4'd3, 64'd0, 2'd0, 4'd11}, // R11 set skip
    '{3'd3, 2'd0, 4'd0,  64'd0, 2'd2, 1'b1, 3'd3, CM, 1'b1, 1'b0, 4'd0, 1'b0, 4'd0, 64'd0, 2'd0, 4'd5},  // R5 skip type
    '{3'd1, 2'd0, 4'd0,  DB, 2'd0, 1'b0, 3'd3, CM, 1'b0, 1'b0, 4'd0, 1'b0, 4'd0, 64'd0, 2'd0, 4'd4},  // R4 skip excluded
    '{3'd2, 2'd0, 4'd0,  64'hFFFF_FFFF_FFFF_FFFF, 2'd0, 1'b0, 3'd3, CM, 1'b0, 1'b0, 4'd0, 1'b0, 4'd0, 64'd0, 2'd0, 4'd10}, // R10
    '{3'd3, 2'd0, 4'd0,  64'd0, 2'd1, 1'b1, 3'd3, CM, 1'b1, 1'b1, 4'd3, 1'b0, 4'd0, 64'd0, 2'd0, 4'd5},  // R5 empty type
    '{3'd4, 2'd2, 4'd0,  DC, 2'd3, 1'b0, 3'd3, CF, 1'b0, 1'b0, 4'd0, 1'b0, 4'd4, 64'd0, 2'd0, 4'd8},  // R8 match write
    '{3'd3, 2'd0, 4'd0,  64'd0, 2'd3, 1'b1, 3'd3, CM, 1'b1, 1'b0, 4'd3, 1'b0, 4'd0, 64'd0, 2'd0, 4'd5},  // R5 RAM type
    '{3'd1, 2'd0, 4'd0,  64'h7777, 2'd0, 1'b0, 3'd3, CM, 1'b0, 1'b0, 4'd0, 1'b0, 4'd0, 64'd0, 2'd0, 4'd6}, // R6 none
    '{3'd4, 2'd2, 4'd0,  DA, 2'd0, 1'b0, 3'd3, CF, 1'b0, 1'b0, 4'd0, 1'b0, 4'd4, 64'd0, 2'd0, 4'd8},  // R8 ignored
    '{3'd5, 2'd0, 4'd0,  64'd0, 2'd0, 1'b0, 3'd3, CD, 1'b0, 1'b0, 4'd0, 1'b0, 4'd0, DB, 2'd2, 4'd8},  // R8 entry 0 kept
    '{3'd7, 2'd0, 4'd14, 64'd0, 2'd0, 1'b0, 3'd3, 3'b000, 1'b0, 1'b0, 4'd0, 1'b0, 4'd0, 64'd0, 2'd0, 4'd9}, // R9 load addr
    '{3'd4, 2'd1, 4'd0,  DD, 2'd0, 1'b0, 3'd3, CF, 1'b0, 1'b0, 4'd0, 1'b0, 4'd4, 64'd0, 2'd0, 4'd9},  // R9 areg write
    '{3'd5, 2'd1, 4'd0,  64'd0, 2'd0, 1'b0, 3'd3, CD, 1'b0, 1'b0, 4'd0, 1'b0, 4'd0, 64'd0, 2'd1, 4'd9}, // R9 next
    '{3'd5, 2'd1, 4'd0,  64'd0, 2'd0, 1'b0, 3'd3, CD, 1'b0, 1'b0, 4'd0, 1'b0, 4'd0, DB, 2'd2, 4'd9},    // R9 wrap
    '{3'd5, 2'd0, 4'd14, 64'd0, 2'd0, 1'b0, 3'd3, CD, 1'b0, 1'b0, 4'd0, 1'b0, 4'd0, DD, 2'd0, 4'd9},    // R9
    '{3'd6, 2'd0, 4'd14, 64'd0, 2'd1, 1'b0, 3'd3, CF, 1'b0, 1'b0, 4'd0, 1'b0, 4'd4, 64'd0, 2'd0, 4'd11}, // R11
    '{3'd5, 2'd0, 4'd14, 64'd0, 2'd0, 1'b0, 3'd3, CD, 1'b0, 1'b0, 4'd0, 1'b0, 4'd0, DD, 2'd1, 4'd11}    // R11 data kept
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic [2:0]    split_cfg;
  logic          cmd_valid;
  logic [2:0]    cmd_op;
  logic [1:0]    cmd_mode;
  logic [AW-1:0] cmd_addr;
  logic [W-1:0]  cmd_data;
  logic [1:0]    cmd_vtype;
  logic          cmd_mask_en;
  logic          match, multi, full;
  logic [AW-1:0] match_addr, free_addr;
  logic [W-1:0]  rd_data;
  logic [1:0]    rd_status;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  seg_cam #(.ENTRIES(16), .SEG_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .split_cfg(split_cfg),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_mode(cmd_mode),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_vtype(cmd_vtype),
    .cmd_mask_en(cmd_mask_en),
    .match(match), .multi(multi), .match_addr(match_addr),
    .full(full), .free_addr(free_addr),
    .rd_data(rd_data), .rd_status(rd_status)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] op, input logic [1:0] mode,
                       input logic [3:0] addr, input logic [63:0] data,
                       input logic [1:0] vt, input logic men, input logic [2:0] split);
    cmd_valid   = 1'b1;
    cmd_op      = op;
    cmd_mode    = mode;
    cmd_addr    = addr;
    cmd_data    = data;
    cmd_vtype   = vt;
    cmd_mask_en = men;
    split_cfg   = split;
    @(negedge clk);
    cmd_valid   = 1'b0;
    cmd_op      = 3'd0;
  endtask

  task automatic check_reset(input string req);
    check(req, "match", 64'(match), 64'd0);
    check(req, "multi", 64'(multi), 64'd0);
    check(req, "match_addr", 64'(match_addr), 64'd0);
    check(req, "full", 64'(full), 64'd0);
    check(req, "free_addr", 64'(free_addr), 64'd0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    cmd_valid = 1'b0; cmd_op = 3'd0; cmd_mode = 2'd0; cmd_addr = '0;
    cmd_data = '0; cmd_vtype = 2'd0; cmd_mask_en = 1'b0; split_cfg = 3'd3;
    @(negedge clk);
    do_reset();

    // R1: reset state
    check_reset("R1");

    // vector table
    for (int k = 0; k < NV; k++) begin
      string rq;
      rq = $sformatf("R%0d v%0d", VECS[k].req, k);
      drive(VECS[k].op, VECS[k].mode, VECS[k].addr, VECS[k].data,
            VECS[k].vt, VECS[k].men, VECS[k].split);
      if (VECS[k].chk[2]) begin
        check(rq, "match", 64'(match), 64'(VECS[k].em));
        check(rq, "multi", 64'(multi), 64'(VECS[k].emm));
        check(rq, "match_addr", 64'(match_addr), 64'(VECS[k].ema));
      end
      if (VECS[k].chk[1]) begin
        check(rq, "full", 64'(full), 64'(VECS[k].ef));
        check(rq, "free_addr", 64'(free_addr), 64'(VECS[k].efa));
      end
      if (VECS[k].chk[0]) begin
        check(rq, "rd_data", rd_data, VECS[k].erd);
        check(rq, "rd_status", 64'(rd_status), 64'(VECS[k].ers));
      end
    end

    // R7: fill the remaining empty entries 4..15 through next-free
    for (int k = 0; k < 12; k++) begin
      drive(3'd4, 2'd3, 4'd0, 64'h100 + 64'(k), 2'd0, 1'b0, 3'd3);
    end
    check("R7", "full", 64'(full), 64'd1);
    check("R7", "free_addr when full", 64'(free_addr), 64'd0);

    // R8: next-free write while full does nothing
    drive(3'd4, 2'd3, 4'd0, 64'hDEAD, 2'd0, 1'b0, 3'd3);
    check("R8", "full after ignored write", 64'(full), 64'd1);
    drive(3'd5, 2'd0, 4'd15, 64'd0, 2'd0, 1'b0, 3'd3);
    check("R8", "entry 15 data", rd_data, 64'h10B);
    check("R8", "entry 15 status", 64'(rd_status), 64'd0);

    // R1: second reset clears the array
    do_reset();
    check_reset("R1");
    drive(3'd5, 2'd0, 4'd0, 64'd0, 2'd0, 1'b0, 3'd3);
    check("R1", "entry 0 data", rd_data, 64'd0);
    check("R1", "entry 0 status", 64'(rd_status), 64'd1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule